// File: doc/BRIEF.md
# Acknowledged-Link Retransmission Sequencer

This block drives the transmitting side of a packet link in which every packet expects an acknowledge. Once a new packet is started it asks the radio to send, then asks it to listen for an acknowledge. A listen window lasts at least a fixed number of microseconds and is held open for as long as an incoming packet is still being received. After listening, the block sits in standby until a programmable delay has elapsed. That delay is counted from the end of the transmission. The block then sends again. An acknowledge that arrives while it is listening ends the sequence at once with a sent pulse.

A 4-bit retry limit caps the number of retransmissions. When a listen window closes with no acknowledge and no retries remain, the block emits a limit pulse. It then stays halted, and ignores new packet starts, until the limit is cleared. A per-packet retry counter shows how many retransmissions the current packet has used. A saturating lost-packet counter records how many packets ran out of retries. All timing is counted in ticks of an external microsecond strobe, so the block works at any clock frequency.

Top module: `retx_sequencer`

## Requirements
- R1: After a synchronous active-low reset, tx_req, listen_req, sent_pulse and limit_pulse are 0, retry_cnt and lost_cnt are 0, and the block is idle.
- R2: pkt_start while idle raises tx_req from the next cycle, clears retry_cnt to 0, and holds tx_req until tx_done.
- R3: tx_done while transmitting drops tx_req and raises listen_req from the next cycle. At the same edge the elapsed-time count restarts from zero.
- R4: The listen window stays open until at least LISTEN_US (250) ticks have been counted since tx_done, and also until rx_busy is low. With ticks on every clock, listen_req falls one cycle after the first cycle in which both conditions hold.
- R5: With no acknowledge and retries left, tx_req rises again once elapsed ticks reach SLOT_US·(delay_code+1), where SLOT_US is 250. It rises one cycle after whichever is later: that point, or the end of the listen window. Each retransmission increments retry_cnt by exactly 1.
- R6: ack_seen during the listen window ends the sequence. sent_pulse is high for exactly one cycle, listen_req drops, and no further transmission follows. ack_seen takes priority over a listen window closing in the same cycle.
- R7: When a listen window closes without an acknowledge and retry_cnt equals retry_limit, limit_pulse is high for one cycle and no retransmission follows. A retry_limit of 0 therefore gives no retransmission at all.
- R8: After a limit pulse the block is halted. pkt_start has no effect and tx_req stays 0 until limit_clear is pulsed, after which pkt_start works again.
- R9: lost_cnt increments by one at each limit pulse and saturates at 15.
- R10: chan_wr clears lost_cnt to 0. When chan_wr falls in the same cycle as the increment of R9, the clear wins.
- R11: Time advances only on cycles with us_tick high. Withholding the tick for N cycles lengthens the listen window and the delay by N cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| delay_code | input | 4 | Retransmit delay code n, wait = 250·(n+1) ticks |
| retry_limit | input | 4 | Maximum number of retransmissions, 0 to 15 |
| pkt_start | input | 1 | Pulse: begin transmitting a new packet |
| tx_done | input | 1 | Pulse: the radio finished sending |
| ack_seen | input | 1 | Pulse: an acknowledge was received |
| rx_busy | input | 1 | A packet is currently being received |
| chan_wr | input | 1 | Pulse: channel setting was written, clears lost_cnt |
| us_tick | input | 1 | One-microsecond strobe |
| limit_clear | input | 1 | Pulse: clear the halt after a limit event |
| tx_req | output | 1 | Request the radio to transmit |
| listen_req | output | 1 | Request the radio to listen for an acknowledge |
| sent_pulse | output | 1 | One-cycle pulse: packet acknowledged |
| limit_pulse | output | 1 | One-cycle pulse: retries exhausted |
| retry_cnt | output | 4 | Retransmissions used by the current packet |
| lost_cnt | output | 4 | Saturating count of packets that hit the limit |

## Verification
The lost-packet counter can be cleared by a channel write in the same cycle as a limit event raises it. The bench provokes this with a retry limit of 0 and ticks on every clock. It counts 250 cycles from the listen request, then raises chan_wr for exactly the cycle in which the window closes. It judges the result by seeing the limit pulse together with a lost count of 0 on the following cycle. The acknowledge-versus-window-end race is approached the same way: acknowledges are placed at random points inside the listen window, and the bench requires a sent pulse with no later transmission.

// File: rtl/retx_pkg.sv
// Shared types for the retransmission sequencer.
// Assumes: all users import this package; widths of counters are fixed here.
package retx_pkg;
    localparam int unsigned CNT_W = 4;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_SEND   = 3'd1,
        ST_LISTEN = 3'd2,
        ST_WAIT   = 3'd3,
        ST_HALT   = 3'd4
    } seq_state_t;
endpackage

// File: rtl/retx_window_timer.sv
// Elapsed-time counter in microsecond ticks, started at the end of a send.
// Assumes: restart and run are mutually exclusive in use; saturates at its maximum.
module retx_window_timer #(
    parameter int unsigned EW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic          run,
    input  logic          tick,
    output logic [EW-1:0] elapsed
);
    localparam logic [EW-1:0] TOP = {EW{1'b1}};

    // Purpose: count ticks while running, zero on restart, hold at the top.
    always_ff @(posedge clk) begin
        if (!rst_n)
            elapsed <= '0;
        else if (restart)
            elapsed <= '0;
        else if (run && tick && elapsed != TOP)
            elapsed <= elapsed + 1'b1;
    end
endmodule

// File: rtl/retx_retry_counter.sv
// Per-packet retransmission counter: cleared at packet start, +1 per resend.
// Assumes: the controller never bumps beyond the configured limit.
module retx_retry_counter
    import retx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             bump,
    output logic [CNT_W-1:0] count
);
    // Purpose: clear or advance the retry count, never wrapping.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (clr)
            count <= '0;
        else if (bump && count != {CNT_W{1'b1}})
            count <= count + 1'b1;
    end

    // R5: the count only moves by one step up or back to zero.
    assert_retry_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (count != $past(count)) |-> (count == '0 || count == $past(count) + 1'b1));
endmodule

// File: rtl/retx_lost_counter.sv
// Saturating lost-packet counter; a clear wins over a simultaneous bump.
// Assumes: bump is a one-cycle event per packet that ran out of retries.
module retx_lost_counter
    import retx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             bump,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};

    // Purpose: clear on channel write, else saturating increment.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (clr)
            count <= '0;
        else if (bump && count != MAXV)
            count <= count + 1'b1;
    end

    // R9: once full, the counter stays full until cleared.
    assert_lost_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(count) == MAXV && !$past(clr)) |-> (count == MAXV));

    // R10: a clear always leaves zero, whatever else happened.
    assert_lost_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (count == '0));
endmodule

// File: rtl/retx_sequencer.sv
// Retransmission sequencer: send, listen for an acknowledge, wait out the
// programmed delay, resend until acknowledged or the retry limit is reached.
// Assumes: pulse inputs are one clock wide; us_tick is a 1 us strobe; the
// delay and limit settings are held stable while a packet is in flight.
module retx_sequencer
    import retx_pkg::*;
#(
    parameter int unsigned SLOT_US   = 250,
    parameter int unsigned LISTEN_US = 250,
    parameter int unsigned CODE_W    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] delay_code,
    input  logic [CNT_W-1:0]  retry_limit,
    input  logic              pkt_start,
    input  logic              tx_done,
    input  logic              ack_seen,
    input  logic              rx_busy,
    input  logic              chan_wr,
    input  logic              us_tick,
    input  logic              limit_clear,
    output logic              tx_req,
    output logic              listen_req,
    output logic              sent_pulse,
    output logic              limit_pulse,
    output logic [CNT_W-1:0]  retry_cnt,
    output logic [CNT_W-1:0]  lost_cnt
);
    localparam int unsigned MAX_WAIT = SLOT_US * (1 << CODE_W);
    localparam int unsigned SPAN     = (MAX_WAIT > LISTEN_US) ? MAX_WAIT : LISTEN_US;
    localparam int unsigned EW       = $clog2(SPAN + 1);

    seq_state_t      state_q, state_d;
    logic [EW-1:0]   elapsed;
    logic [EW-1:0]   wait_lim;
    logic            listen_done, wait_done, retries_left;
    logic            t_restart, t_run;
    logic            r_clr, r_bump, give_up, acked;

    assign wait_lim     = EW'((32'(delay_code) + 32'd1) * SLOT_US);
    assign listen_done  = (elapsed >= EW'(LISTEN_US)) && !rx_busy;
    assign wait_done    = (elapsed >= wait_lim);
    assign retries_left = (retry_cnt < retry_limit);

    // Purpose: next-state and event selection for the sequence.
    always_comb begin
        state_d   = state_q;
        t_restart = 1'b0;
        r_clr     = 1'b0;
        r_bump    = 1'b0;
        give_up   = 1'b0;
        acked     = 1'b0;
        case (state_q)
            ST_IDLE: if (pkt_start) begin
                state_d = ST_SEND;
                r_clr   = 1'b1;
            end
            ST_SEND: if (tx_done) begin
                state_d   = ST_LISTEN;
                t_restart = 1'b1;
            end
            ST_LISTEN: if (ack_seen) begin
                state_d = ST_IDLE;
                acked   = 1'b1;
            end else if (listen_done) begin
                if (retries_left) begin
                    state_d = ST_WAIT;
                end else begin
                    state_d = ST_HALT;
                    give_up = 1'b1;
                end
            end
            ST_WAIT: if (wait_done) begin
                state_d = ST_SEND;
                r_bump  = 1'b1;
            end
            ST_HALT: if (limit_clear) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    assign t_run = (state_q == ST_LISTEN) || (state_q == ST_WAIT);

    // Purpose: state register and one-cycle event outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            sent_pulse  <= 1'b0;
            limit_pulse <= 1'b0;
        end else begin
            state_q     <= state_d;
            sent_pulse  <= acked;
            limit_pulse <= give_up;
        end
    end

    assign tx_req     = (state_q == ST_SEND);
    assign listen_req = (state_q == ST_LISTEN);

    retx_window_timer #(.EW(EW)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (t_restart),
        .run     (t_run),
        .tick    (us_tick),
        .elapsed (elapsed)
    );

    retx_retry_counter u_retry (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (r_clr),
        .bump  (r_bump),
        .count (retry_cnt)
    );

    retx_lost_counter u_lost (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (chan_wr),
        .bump  (give_up),
        .count (lost_cnt)
    );

    // R3: never asked to send and listen at once.
    assert_req_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_req && listen_req));

    // R4: a window closed without an acknowledge lasted the minimum and saw no busy.
    assert_listen_min_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(listen_req) && !$past(ack_seen)) |->
            ($past(elapsed) >= EW'(LISTEN_US) && !$past(rx_busy)));

    // R6: the sent pulse lasts one cycle and is not followed by a send.
    assert_sent_once_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sent_pulse |=> (!sent_pulse && !tx_req));

    // R7: a limit pulse is one cycle and never coincides with a send.
    assert_limit_once_R7: assert property (@(posedge clk) disable iff (!rst_n)
        limit_pulse |-> (!tx_req && !listen_req) ##1 !limit_pulse);

    // R8: while halted and not cleared, no send request appears.
    assert_halt_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HALT && !limit_clear) |=> !tx_req);
endmodule

// File: tb/retx_sequencer_test.sv
// Self-checking bench: directed corner cases plus seeded random packets.
module retx_sequencer_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] delay_code = '0;
    logic [3:0] retry_limit = 4'd3;
    logic       pkt_start = 1'b0, tx_done = 1'b0, ack_seen = 1'b0;
    logic       rx_busy = 1'b0, chan_wr = 1'b0, us_tick = 1'b1, limit_clear = 1'b0;
    logic       tx_req, listen_req, sent_pulse, limit_pulse;
    logic [3:0] retry_cnt, lost_cnt;

    int checks = 0;
    int errors = 0;
    int exp_lost = 0;

    always #4 clk = ~clk;

    retx_sequencer uut (
        .clk(clk), .rst_n(rst_n), .delay_code(delay_code), .retry_limit(retry_limit),
        .pkt_start(pkt_start), .tx_done(tx_done), .ack_seen(ack_seen), .rx_busy(rx_busy),
        .chan_wr(chan_wr), .us_tick(us_tick), .limit_clear(limit_clear),
        .tx_req(tx_req), .listen_req(listen_req), .sent_pulse(sent_pulse),
        .limit_pulse(limit_pulse), .retry_cnt(retry_cnt), .lost_cnt(lost_cnt)
    );

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Expected cycles from tx_done to the next tx_req, per R4/R5/R11.
    function automatic int exp_gap(input int code, input int lend, input int extra);
        return imax(250 * (code + 1) + extra, lend) + 1;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic clear_halt();
        pkt_start = 1'b1; @(negedge clk); pkt_start = 1'b0;
        repeat (3) @(negedge clk);
        check(tx_req == 1'b0, "R8 start ignored while halted", int'(tx_req), 0);
        limit_clear = 1'b1; @(negedge clk); limit_clear = 1'b0;
        check(tx_req == 1'b0, "R8 idle after clear", int'(tx_req), 0);
    endtask

    // One packet; ack_at = attempt index that gets acknowledged (>lim: none).
    task automatic run_pkt(input int code, input int lim, input int ack_at,
                           input int busy_until, input bit gate, input int ack_wait);
        int n;
        int lend;
        int extra;
        bit busy;
        bit g;
        delay_code  = 4'(code);
        retry_limit = 4'(lim);
        @(negedge clk);
        pkt_start = 1'b1; @(negedge clk); pkt_start = 1'b0;
        check(tx_req == 1'b1, "R2 send after start", int'(tx_req), 1);
        check(retry_cnt == 4'd0, "R2 retry count cleared", int'(retry_cnt), 0);
        for (int a = 0; a < 17; a++) begin
            check(retry_cnt == 4'(a), "R5 retry count per attempt", int'(retry_cnt), a);
            @(negedge clk); @(negedge clk);
            check(tx_req == 1'b1, "R2 send held", int'(tx_req), 1);
            tx_done = 1'b1; @(negedge clk); tx_done = 1'b0;
            check(listen_req == 1'b1 && tx_req == 1'b0, "R3 listen after done",
                  int'(listen_req), 1);
            if (a == ack_at) begin
                repeat (ack_wait) @(negedge clk);
                ack_seen = 1'b1; @(negedge clk); ack_seen = 1'b0;
                check(sent_pulse == 1'b1 && listen_req == 1'b0, "R6 sent pulse",
                      int'(sent_pulse), 1);
                @(negedge clk);
                check(sent_pulse == 1'b0 && tx_req == 1'b0, "R6 single pulse, no resend",
                      int'(sent_pulse) + int'(tx_req), 0);
                check(retry_cnt == 4'(a), "R5 retry count at ack", int'(retry_cnt), a);
                return;
            end
            busy  = (a == 0) && (busy_until > 0);
            g     = (a == 0) && gate;
            extra = g ? 100 : 0;
            lend  = (busy ? imax(251, busy_until + 1) : 251) + extra;
            if (busy) rx_busy = 1'b1;
            n = 0;
            do begin
                @(negedge clk);
                n++;
                if (busy && n == busy_until) begin
                    check(listen_req == 1'b1, "R4 listen held while busy", int'(listen_req), 1);
                    rx_busy = 1'b0;
                end
                if (g && n == 50) us_tick = 1'b0;
                if (g && n == 150) us_tick = 1'b1;
            end while (!tx_req && !limit_pulse && n < 8000);
            if (a == lim) begin
                check(limit_pulse == 1'b1 && n == lend, "R7 limit at window end", n, lend);
                exp_lost = imax(exp_lost, 0);
                if (exp_lost < 15) exp_lost++;
                check(lost_cnt == 4'(exp_lost), "R9 lost count", int'(lost_cnt), exp_lost);
                check(retry_cnt == 4'(lim), "R7 retries used", int'(retry_cnt), lim);
                @(negedge clk);
                check(limit_pulse == 1'b0 && tx_req == 1'b0, "R7 one-cycle limit",
                      int'(limit_pulse), 0);
                clear_halt();
                return;
            end
            check(tx_req == 1'b1 && n == exp_gap(code, lend, extra),
                  g ? "R11 tick gated delay" : (busy ? "R4 extended window" : "R5 retransmit delay"),
                  n, exp_gap(code, lend, extra));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int seed;
        int lim, code, ack_at;
        seed = $urandom(32'd20240611);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(!tx_req && !listen_req && !sent_pulse && !limit_pulse,
              "R1 outputs idle", int'(tx_req) + int'(listen_req), 0);
        check(retry_cnt == 4'd0 && lost_cnt == 4'd0, "R1 counters zero",
              int'(retry_cnt) + int'(lost_cnt), 0);

        // Directed: default limit 3, shortest delay, no acknowledge.
        run_pkt(0, 3, 99, 0, 1'b0, 0);
        // Longer delay with an acknowledge on the second resend.
        run_pkt(2, 4, 2, 0, 1'b0, 17);
        // Acknowledge immediately on the first listen cycle.
        run_pkt(1, 2, 0, 0, 1'b0, 0);
        // Busy extends the window beyond the whole delay (R4).
        run_pkt(0, 1, 99, 600, 1'b0, 0);
        // Busy extension shorter than a long delay (R4).
        run_pkt(3, 1, 1, 400, 1'b0, 100);
        // Tick withheld for 100 cycles (R11).
        run_pkt(0, 1, 99, 0, 1'b1, 0);
        // Retry limit 0: no resend at all (R7).
        run_pkt(2, 0, 99, 0, 1'b0, 0);

        // R10 plain clear.
        chan_wr = 1'b1; @(negedge clk); chan_wr = 1'b0;
        check(lost_cnt == 4'd0, "R10 channel write clears", int'(lost_cnt), 0);
        exp_lost = 0;

        // R9 saturation over 17 limit events.
        for (int k = 0; k < 17; k++) run_pkt(0, 0, 99, 0, 1'b0, 0);
        check(lost_cnt == 4'd15, "R9 saturated at 15", int'(lost_cnt), 15);

        // R10 clear in the same cycle as the increment.
        delay_code = 4'd0; retry_limit = 4'd0;
        @(negedge clk);
        pkt_start = 1'b1; @(negedge clk); pkt_start = 1'b0;
        @(negedge clk);
        tx_done = 1'b1; @(negedge clk); tx_done = 1'b0;
        repeat (250) @(negedge clk);
        chan_wr = 1'b1; @(negedge clk); chan_wr = 1'b0;
        check(limit_pulse == 1'b1, "R10 limit in clear cycle", int'(limit_pulse), 1);
        check(lost_cnt == 4'd0, "R10 clear wins over increment", int'(lost_cnt), 0);
        exp_lost = 0;
        @(negedge clk);
        clear_halt();

        // Seeded random packets.
        for (int p = 0; p < 14; p++) begin
            code   = int'($urandom % 3);
            lim    = int'($urandom % 4);
            ack_at = int'($urandom % (lim + 2));
            run_pkt(code, lim, ack_at, 0, 1'b0, int'($urandom % 240));
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule